// File: doc/BRIEF.md
# Modem Control and Loopback Status Unit

This unit holds the modem control register of a 16550-style serial port and builds the modem status register that software reads back. The control register drives four line outputs and a loopback switch. When loopback is on, each control output is routed back onto one status line. When loopback is off, the status lines show fixed levels: carrier detect and data-set-ready high, clear-to-send and ring low.

Each status line has a change bit. A change bit sets when its line changes because of a control write. The ring change bit is different: it sets only on the trailing edge of ring. Change bits stay set until software reads the status register, and that read clears them. A single flag tells the interrupt logic that at least one change bit is set.

The host side has two select-based ports. The write port's select chooses control (0) or status (1). The read port's select also chooses control (0) or status (1). Read data follows the read select in the same cycle. Only a status read with `rd_en` high has a side effect.

Top module: `modem_loop_status`

## Requirements
- R1: A control write (`wr_en`, `wr_sel`=0) stores `wr_data[4:0]`. Reading control (`rd_sel`=0) shows those bits with bits 7..5 at zero. Control layout: DTR bit 0, RTS bit 1, OUT1 bit 2, OUT2 bit 3, LOOP bit 4.
- R2: With LOOP set, the status lines follow control. CTS (status bit 4) = RTS, DSR (bit 5) = DTR, RI (bit 6) = OUT1, DCD (bit 7) = OUT2.
- R3: With LOOP clear, status bits 7..4 read 1,0,1,0 (DCD and DSR high, RI and CTS low), whatever the other control bits hold.
- R4: A control write that changes CTS, DSR or DCD sets that line's change bit. These are status bit 0, bit 1 and bit 3.
- R5: The ring change bit (status bit 2) sets only when RI goes from 1 to 0. It does not set when RI goes from 0 to 1.
- R6: Change bits stay set across later control writes. A status read (`rd_en`, `rd_sel`=1) returns the current value, and the change bits are zero from the next cycle on.
- R7: Writes with `wr_sel`=1 change neither the status nor the control register.
- R8: `delta_any` is high exactly when any of status bits 3..0 is set.
- R9: A control write and a status read can happen in the same cycle. The read returns the value from before the write. The old change bits are cleared, and then the changes from this write are merged in.
- R10: After reset, control reads 0x00, status reads 0xA0, and `delta_any` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 status (ignored) |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Host read strobe (side effects only) |
| rd_sel | input | 1 | Read target: 0 control, 1 status |
| rd_data | output | 8 | Selected register, combinational |
| delta_any | output | 1 | Any status change bit set |

## Verification
The bench builds the unit with its default parameters: a 5-bit control field and idle line levels 1,0,1,0. With these values every status line is reachable in both levels through loopback writes. Each line can be driven on its own, so a rise and a fall of each line, including the ring trailing edge, can be produced by single control writes. The 5-bit field also lets one write of all ones show the masking of bits 7..5.

// File: rtl/mls_pkg.sv
package mls_pkg;
  localparam int REG_W  = 8;
  localparam int CTL_W  = 5;
  localparam int LINE_N = 4;
  // control bit positions
  localparam int C_DTR  = 0;
  localparam int C_RTS  = 1;
  localparam int C_OUT1 = 2;
  localparam int C_OUT2 = 3;
  localparam int C_LOOP = 4;
  // line index (status bit = index + 4, change bit = index)
  localparam int L_CTS  = 0;
  localparam int L_DSR  = 1;
  localparam int L_RI   = 2;
  localparam int L_DCD  = 3;
  localparam logic SEL_CTL = 1'b0;
  localparam logic SEL_STS = 1'b1;
endpackage

// File: rtl/mls_line_map.sv
module mls_line_map
  import mls_pkg::*;
#(
  parameter int CW = CTL_W,
  parameter int LN = LINE_N,
  parameter logic [LN-1:0] IDLE_LINES = 4'b1010
) (
  input  logic [CW-1:0] ctl,
  output logic [LN-1:0] lines
);
  logic [LN-1:0] looped;

  always_comb begin
    looped         = '0;
    looped[L_CTS]  = ctl[C_RTS];
    looped[L_DSR]  = ctl[C_DTR];
    looped[L_RI]   = ctl[C_OUT1];
    looped[L_DCD]  = ctl[C_OUT2];
    lines          = ctl[C_LOOP] ? looped : IDLE_LINES;
  end
endmodule

// File: rtl/mls_delta_detect.sv
module mls_delta_detect
  import mls_pkg::*;
#(
  parameter int LN = LINE_N,
  parameter logic [LN-1:0] FALL_ONLY = 4'b0100
) (
  input  logic [LN-1:0] old_lines,
  input  logic [LN-1:0] new_lines,
  output logic [LN-1:0] events
);
  for (genvar i = 0; i < LN; i++) begin : g_line
    if (FALL_ONLY[i]) begin : g_fall
      assign events[i] = old_lines[i] & ~new_lines[i];
    end else begin : g_any
      assign events[i] = old_lines[i] ^ new_lines[i];
    end
  end
endmodule

// File: rtl/modem_loop_status.sv
module modem_loop_status
  import mls_pkg::*;
#(
  parameter int DATA_W = REG_W,
  parameter int CW     = CTL_W,
  parameter logic [LINE_N-1:0] IDLE_LINES = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              delta_any
);
  localparam int LN  = LINE_N;
  localparam int PAD = DATA_W - CW;

  logic [CW-1:0] ctl_q, ctl_d;
  logic [LN-1:0] delta_q, delta_d;
  logic [LN-1:0] lines_q, lines_d, events;
  logic          ctl_wr, sts_rd, ctl_en, delta_en;
  logic          unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:CW];

  mls_line_map #(.CW(CW), .LN(LN), .IDLE_LINES(IDLE_LINES)) u_map_cur (
    .ctl(ctl_q), .lines(lines_q)
  );
  mls_line_map #(.CW(CW), .LN(LN), .IDLE_LINES(IDLE_LINES)) u_map_nxt (
    .ctl(ctl_d), .lines(lines_d)
  );
  mls_delta_detect #(.LN(LN), .FALL_ONLY(4'b0100)) u_det (
    .old_lines(lines_q), .new_lines(lines_d), .events(events)
  );

  // next state
  always_comb begin
    ctl_wr   = wr_en && (wr_sel == SEL_CTL);
    sts_rd   = rd_en && (rd_sel == SEL_STS);
    ctl_en   = ctl_wr;
    ctl_d    = ctl_wr ? wr_data[CW-1:0] : ctl_q;
    delta_en = ctl_wr || sts_rd;
    delta_d  = (sts_rd ? '0 : delta_q) | events;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delta_q <= '0;
    end else if (delta_en) begin
      delta_q <= delta_d;
    end
  end

  // outputs
  always_comb begin
    if (rd_sel == SEL_STS) rd_data = {lines_q, delta_q};
    else                   rd_data = {{PAD{1'b0}}, ctl_q};
    delta_any = |delta_q;
  end
endmodule

// File: rtl/mls_checker.sv
module mls_checker
  import mls_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] wr_data,
  input logic       rd_en,
  input logic       rd_sel,
  input logic       delta_any,
  input logic [4:0] ctl_q,
  input logic [7:0] sts
);
  // R1: control keeps the low five written bits
  a_r1_ctl_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CTL) |=> ctl_q == $past(wr_data[4:0]));

  // R2: loopback mirrors control outputs
  a_r2_loop_map: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[C_LOOP] |-> (sts[7:4] == {ctl_q[C_OUT2], ctl_q[C_OUT1], ctl_q[C_DTR], ctl_q[C_RTS]}));

  // R3: fixed levels outside loopback
  a_r3_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[C_LOOP] |-> sts[7:4] == 4'b1010);

  // R5: ring change bit only on trailing edge
  a_r5_teri_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[2]) |-> ($past(sts[6]) && !sts[6]));

  // R6: without a status read change bits never drop
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_sel == SEL_STS) |=> ((sts[3:0] & $past(sts[3:0])) == $past(sts[3:0])));

  // R7: status-select writes alone leave everything unchanged
  a_r7_sts_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_STS && !rd_en) |=> ($stable(sts) && $stable(ctl_q)));

  // R8: flag only rises through a control write
  a_r8_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(delta_any) |-> $past(wr_en && wr_sel == SEL_CTL));
endmodule

bind modem_loop_status mls_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .rd_en(rd_en), .rd_sel(rd_sel), .delta_any(delta_any),
  .ctl_q(ctl_q), .sts({lines_q, delta_q})
);

// File: tb/modem_loop_status_tb.sv
module modem_loop_status_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, rd_en = 1'b0, rd_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       delta_any;
  int         n_chk = 0, n_fail = 0;
  logic       done = 1'b0;

  always #4 clk = ~clk;

  modem_loop_status dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .delta_any(delta_any)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // peek without side effect
  task automatic peek(input logic sel, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b0; rd_sel = sel;
    #1 v = rd_data;
  endtask

  task automatic rd_sts(output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = 1'b1;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    peek(1'b0, v); chk("R10 ctl reset", v, 8'h00);
    peek(1'b1, v); chk("R10 sts reset", v, 8'hA0);
    chk("R10 flag reset", {7'd0, delta_any}, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    wr(1'b0, 8'hFF);
    peek(1'b0, v); chk("R1 ctl mask", v, 8'h1F);
    peek(1'b1, v); chk("R2 R4 all on", v, 8'hF1);
    chk("R8 flag set", {7'd0, delta_any}, 8'h01);
    rd_sts(v); chk("R6 read value", v, 8'hF1);
    peek(1'b1, v); chk("R6 cleared", v, 8'hF0);
    chk("R8 flag clear", {7'd0, delta_any}, 8'h00);
  endtask

  task automatic t_loop_map();
    logic [7:0] v;
    wr(1'b0, 8'h12); rd_sts(v); chk("R2 R4 R5 rts only", v, 8'h1E);
    wr(1'b0, 8'h11); rd_sts(v); chk("R2 R4 dtr only", v, 8'h23);
    wr(1'b0, 8'h14); rd_sts(v); chk("R2 R4 out1 only", v, 8'h42);
    wr(1'b0, 8'h18); rd_sts(v); chk("R2 R5 out2 only", v, 8'h8C);
  endtask

  task automatic t_sticky();
    logic [7:0] v;
    wr(1'b0, 8'h1A); wr(1'b0, 8'h18); wr(1'b0, 8'h19);
    rd_sts(v); chk("R6 sticky", v, 8'hA3);
    peek(1'b1, v); chk("R6 cleared after", v, 8'hA0);
  endtask

  task automatic t_ri_rise();
    logic [7:0] v;
    wr(1'b0, 8'h1D);
    peek(1'b1, v); chk("R5 ri rise no delta", v, 8'hE0);
    chk("R8 flag low", {7'd0, delta_any}, 8'h00);
    wr(1'b0, 8'h00);
    rd_sts(v); chk("R3 R5 leave loop", v, 8'hA4);
  endtask

  task automatic t_idle();
    logic [7:0] v;
    wr(1'b0, 8'h0F);
    peek(1'b1, v); chk("R3 outputs no effect", v, 8'hA0);
    peek(1'b0, v); chk("R1 ctl readback", v, 8'h0F);
  endtask

  task automatic t_sts_write();
    logic [7:0] v;
    wr(1'b1, 8'hFF);
    peek(1'b1, v); chk("R7 sts unchanged", v, 8'hA0);
    peek(1'b0, v); chk("R7 ctl unchanged", v, 8'h0F);
  endtask

  task automatic t_same_cycle();
    logic [7:0] v;
    wr(1'b0, 8'h12);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h11;
    rd_en = 1'b1; rd_sel = 1'b1;
    #1 v = rd_data;
    chk("R9 pre-write value", v, 8'h1B);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    rd_sts(v); chk("R9 merged after clear", v, 8'h23);
    peek(1'b1, v); chk("R6 final clear", v, 8'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mask();
    t_loop_map();
    t_sticky();
    t_ri_rise();
    t_idle();
    t_sts_write();
    t_same_cycle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule